// File: doc/BRIEF.md
# Four-Channel Counter Read-Modify-Write Engine

This block updates statistics counters held in an external memory that has a separate read port and a separate write port. Four request channels run side by side. On each channel, a valid request sends a read of its counter address out on the read port in the same cycle. The request's context travels through a delay line whose length matches the memory's read latency. When the old word comes back, the block adds the packet and byte increments and sends the result out on the write port. A readback request takes the same path, but it hands the old word to the processor and writes zero in its place. This clears the counter for the next collection interval.

Several updates to one counter can follow each other while earlier writes are still on their way to memory. To handle this, the block keeps a short history of recent results and forwards the newest matching one into the add stage instead of the stale memory word. A parameter selects the address mapping. In the free mapping, any channel may use any address. In the banked mapping, the lower half of the channels must use odd addresses and the upper half even ones, so that the two memory ports never collide in one bank. A request that breaks the banked mapping is discarded and latches an error flag.

Requests in the same cycle on different channels are assumed to target different addresses; an upstream merge stage provides this.

Top module: `rmw_counter_quad`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, the block clears `wr_en`, `rsp_valid` and `map_err`. All three read zero in the cycle after that edge.
- R2: A request that is accepted on channel c drives `rd_en[c]` high in the same cycle, with `rd_addr` equal to the request address. The read port is never driven without a request.
- R3: The write for a request accepted in cycle t appears on the same channel's write port in cycle t+RD_LAT+1, with the request's address.
- R4: The counter word is 72 bits: bits [71:40] hold the packet count and bits [39:0] hold the byte count. An update adds each increment to its own field, and each field wraps modulo its own width without carrying into the other.
- R5: A readback request drives `rsp_valid[c]` high in cycle t+RD_LAT+1. `rsp_data` carries the counter's value before the readback, and the word written in the same cycle is zero.
- R6: A request sees the effect of every earlier request to the same address, including one made on another channel in the cycle just before, whose write has not yet reached memory.
- R7: With BANKED=0, every channel accepts both odd and even addresses, and `map_err` stays low.
- R8: With BANKED=1, channels 0 and 1 need address bit 0 equal to 1, and channels 2 and 3 need it equal to 0. A violating request causes no read, no write and no change to memory.
- R9: A violating request sets `map_err` in the next cycle. `map_err` then stays high until reset.
- R10: Requests on all four channels in the same cycle, to distinct addresses, are each updated independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NCH | Request present, one bit per channel |
| req_rdback | input | NCH | Request is a processor readback (return old value, write zero) |
| req_addr | input | NCH*AW | Counter address per channel |
| req_pkt_inc | input | NCH*32 | Packet increment per channel |
| req_byte_inc | input | NCH*40 | Byte increment per channel |
| rd_en | output | NCH | Memory read strobe per channel |
| rd_addr | output | NCH*AW | Memory read address per channel |
| rd_data | input | NCH*72 | Memory read data, RD_LAT cycles after `rd_en` |
| wr_en | output | NCH | Memory write strobe per channel |
| wr_addr | output | NCH*AW | Memory write address per channel |
| wr_data | output | NCH*72 | Memory write data per channel |
| rsp_valid | output | NCH | Readback result valid per channel |
| rsp_data | output | NCH*72 | Readback old counter value per channel |
| map_err | output | 1 | Sticky banked-mapping violation flag |

## Verification
The case that matters most is a readback that lands in the same cycle as the forwarding of an update that is still in flight to the same counter. The bench provokes it by sending three updates to one address on channels 0, 1 and 2 in consecutive cycles, then a readback of that address on channel 3 in the next cycle. None of these writes has reached memory when the readback's read is sampled. The bench judges the result by comparing the returned word with the sum of all three updates, and by checking that a later update to the same counter starts again from zero.

// File: rtl/rmw_pkg.sv
// Shared constants and arithmetic for the counter read-modify-write engine.
// Assumes a 72-bit counter word: packet count in the upper 32 bits, byte count below.
package rmw_pkg;
    localparam int PKT_W  = 32;
    localparam int BYTE_W = 40;
    localparam int WORD_W = PKT_W + BYTE_W;

    // Adds both increments to the word, each field wrapping on its own.
    function automatic logic [WORD_W-1:0] bump_word(
        input logic [WORD_W-1:0] w,
        input logic [PKT_W-1:0]  p,
        input logic [BYTE_W-1:0] b
    );
        logic [PKT_W-1:0]  np;
        logic [BYTE_W-1:0] nb;
        np = w[WORD_W-1 -: PKT_W] + p;
        nb = w[BYTE_W-1:0] + b;
        return {np, nb};
    endfunction
endpackage

// File: rtl/rmw_map_check.sv
// Filters requests against the address mapping selected by BANKED.
// Assumes NCH is even; in banked mode the lower half of the channels owns odd
// addresses and the upper half owns even addresses.
module rmw_map_check #(
    parameter int NCH    = 4,
    parameter int AW     = 8,
    parameter int BANKED = 0
) (
    input  logic [NCH-1:0]    req_valid,
    input  logic [NCH*AW-1:0] req_addr,
    output logic [NCH-1:0]    legal,
    output logic [NCH-1:0]    viol
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ok;
        if (BANKED != 0) begin : g_bank
            localparam logic WANT_ODD = (c < NCH/2);
            // Purpose: address parity must match the channel's half.
            assign ok = (req_addr[c*AW] == WANT_ODD);
        end else begin : g_free
            // Purpose: unconstrained mapping accepts every address.
            assign ok = 1'b1;
        end
        assign legal[c] = req_valid[c] & ok;
        assign viol[c]  = req_valid[c] & ~ok;
    end
endmodule

// File: rtl/rmw_ctx_pipe.sv
// Delay line of DEPTH register stages used to align request context with read data.
// Assumes DEPTH >= 1; all stages clear on synchronous active-low reset.
module rmw_ctx_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    // Purpose: shift the context one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/rmw_fwd_unit.sv
// Forwarding store for results not yet visible in memory. Holds the write stage
// (supplied from outside) plus HIST-1 older cycles of results, and replaces the
// memory word by the newest result whose address matches.
// Assumes HIST >= 2 and that one cycle's results carry distinct addresses.
module rmw_fwd_unit import rmw_pkg::*; #(
    parameter int NCH  = 4,
    parameter int AW   = 8,
    parameter int HIST = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        new_vld,
    input  logic [NCH*AW-1:0]     new_addr,
    input  logic [NCH*WORD_W-1:0] new_data,
    input  logic [NCH*AW-1:0]     lkp_addr,
    input  logic [NCH*WORD_W-1:0] mem_data,
    output logic [NCH*WORD_W-1:0] base
);
    localparam int OLD = HIST - 1;

    logic [NCH-1:0]        old_vld  [OLD];
    logic [NCH*AW-1:0]     old_addr [OLD];
    logic [NCH*WORD_W-1:0] old_data [OLD];

    // Purpose: age the valid flags of past results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < OLD; k++) old_vld[k] <= '0;
        end else begin
            old_vld[0] <= new_vld;
            for (int k = 1; k < OLD; k++) old_vld[k] <= old_vld[k-1];
        end
    end

    // Purpose: age the addresses and data of past results.
    always_ff @(posedge clk) begin
        old_addr[0] <= new_addr;
        old_data[0] <= new_data;
        for (int k = 1; k < OLD; k++) begin
            old_addr[k] <= old_addr[k-1];
            old_data[k] <= old_data[k-1];
        end
    end

    // Purpose: pick the newest matching result, oldest first so newer ones win.
    always_comb begin
        base = mem_data;
        for (int c = 0; c < NCH; c++) begin
            for (int k = OLD-1; k >= 0; k--) begin
                for (int j = 0; j < NCH; j++) begin
                    if (old_vld[k][j] && old_addr[k][j*AW +: AW] == lkp_addr[c*AW +: AW])
                        base[c*WORD_W +: WORD_W] = old_data[k][j*WORD_W +: WORD_W];
                end
            end
            for (int j = 0; j < NCH; j++) begin
                if (new_vld[j] && new_addr[j*AW +: AW] == lkp_addr[c*AW +: AW])
                    base[c*WORD_W +: WORD_W] = new_data[j*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/rmw_counter_quad.sv
// Multi-channel counter read-modify-write engine. Reads on one memory port,
// writes on the other, aligns context to RD_LAT cycles of read latency, forwards
// results still in flight and supports readback-and-clear.
// Assumes the memory returns rd_data exactly RD_LAT cycles after rd_en, and that
// requests in one cycle use distinct addresses.
module rmw_counter_quad import rmw_pkg::*; #(
    parameter int NCH    = 4,
    parameter int AW     = 8,
    parameter int RD_LAT = 3,
    parameter int BANKED = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        req_valid,
    input  logic [NCH-1:0]        req_rdback,
    input  logic [NCH*AW-1:0]     req_addr,
    input  logic [NCH*PKT_W-1:0]  req_pkt_inc,
    input  logic [NCH*BYTE_W-1:0] req_byte_inc,
    output logic [NCH-1:0]        rd_en,
    output logic [NCH*AW-1:0]     rd_addr,
    input  logic [NCH*WORD_W-1:0] rd_data,
    output logic [NCH-1:0]        wr_en,
    output logic [NCH*AW-1:0]     wr_addr,
    output logic [NCH*WORD_W-1:0] wr_data,
    output logic [NCH-1:0]        rsp_valid,
    output logic [NCH*WORD_W-1:0] rsp_data,
    output logic                  map_err
);
    localparam int CTX_W = 1 + AW + PKT_W + BYTE_W;
    localparam int HIST  = RD_LAT + 1;

    logic [NCH-1:0]        legal, viol;
    logic [NCH*CTX_W-1:0]  ctx_d, ctx_q;
    logic [NCH-1:0]        vld_q;
    logic [NCH-1:0]        m_rb;
    logic [NCH*AW-1:0]     m_addr;
    logic [NCH*WORD_W-1:0] m_base, m_new;

    rmw_map_check #(.NCH(NCH), .AW(AW), .BANKED(BANKED)) u_map (
        .req_valid(req_valid), .req_addr(req_addr), .legal(legal), .viol(viol)
    );

    assign rd_en   = legal;
    assign rd_addr = req_addr;

    for (genvar c = 0; c < NCH; c++) begin : g_pack
        assign ctx_d[c*CTX_W +: CTX_W] = {req_rdback[c], req_addr[c*AW +: AW],
                                          req_pkt_inc[c*PKT_W +: PKT_W],
                                          req_byte_inc[c*BYTE_W +: BYTE_W]};
    end

    rmw_ctx_pipe #(.W(NCH), .DEPTH(RD_LAT)) u_vld_pipe (
        .clk(clk), .rst_n(rst_n), .din(legal), .dout(vld_q)
    );
    rmw_ctx_pipe #(.W(NCH*CTX_W), .DEPTH(RD_LAT)) u_ctx_pipe (
        .clk(clk), .rst_n(rst_n), .din(ctx_d), .dout(ctx_q)
    );

    rmw_fwd_unit #(.NCH(NCH), .AW(AW), .HIST(HIST)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .new_vld(wr_en), .new_addr(wr_addr), .new_data(wr_data),
        .lkp_addr(m_addr), .mem_data(rd_data), .base(m_base)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_mod
        logic [CTX_W-1:0] ctx;
        assign ctx                   = ctx_q[c*CTX_W +: CTX_W];
        assign m_rb[c]               = ctx[CTX_W-1];
        assign m_addr[c*AW +: AW]    = ctx[CTX_W-2 -: AW];
        // Purpose: readback clears the counter, otherwise add both increments.
        assign m_new[c*WORD_W +: WORD_W] = m_rb[c] ? '0 :
            bump_word(m_base[c*WORD_W +: WORD_W], ctx[BYTE_W +: PKT_W], ctx[BYTE_W-1:0]);
    end

    // Purpose: register the write port and the readback response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            wr_en     <= vld_q;
            wr_addr   <= m_addr;
            wr_data   <= m_new;
            rsp_valid <= vld_q & m_rb;
            rsp_data  <= m_base;
        end
    end

    // Purpose: latch any mapping violation until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     map_err <= 1'b0;
        else if (|viol) map_err <= 1'b1;
    end
endmodule

// File: rtl/rmw_counter_quad_chk.sv
// Property checker for rmw_counter_quad, attached by bind below.
// Assumes the same parameters as the bound instance.
module rmw_counter_quad_chk import rmw_pkg::*; #(
    parameter int NCH    = 4,
    parameter int AW     = 8,
    parameter int BANKED = 0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH-1:0]        req_valid,
    input logic [NCH-1:0]        rd_en,
    input logic [NCH*AW-1:0]     rd_addr,
    input logic [NCH-1:0]        wr_en,
    input logic [NCH*WORD_W-1:0] wr_data,
    input logic [NCH-1:0]        rsp_valid,
    input logic                  map_err
);
    logic after_rst;

    // Purpose: mark the first cycle following a reset cycle.
    always_ff @(posedge clk) after_rst <= !rst_n;

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst |-> (wr_en == '0 && rsp_valid == '0 && !map_err));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        map_err |=> map_err);

    a_r9_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_err) |-> $past(req_valid) != '0);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic WANT_ODD = (c < NCH/2);

        a_r2_read_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[c] |-> req_valid[c]);

        a_r5_readback_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[c] |-> (wr_en[c] && wr_data[c*WORD_W +: WORD_W] == '0));

        a_r8_bank_parity: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[c] && BANKED != 0) |-> rd_addr[c*AW] == WANT_ODD);
    end
endmodule

bind rmw_counter_quad rmw_counter_quad_chk #(.NCH(NCH), .AW(AW), .BANKED(BANKED)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rsp_valid(rsp_valid), .map_err(map_err)
);

// File: tb/sim_rmw_counter_quad.sv
// Behavioural two-port memory: reads return after RD_LAT edges, writes land on the edge.
module sim_mem #(
    parameter int NCH    = 4,
    parameter int AW     = 8,
    parameter int RD_LAT = 3
) (
    input  logic                clk,
    input  logic [NCH-1:0]      rd_en,
    input  logic [NCH*AW-1:0]   rd_addr,
    output logic [NCH*72-1:0]   rd_data,
    input  logic [NCH-1:0]      wr_en,
    input  logic [NCH*AW-1:0]   wr_addr,
    input  logic [NCH*72-1:0]   wr_data
);
    logic [71:0]       mem  [2**AW];
    logic [NCH*72-1:0] pipe [RD_LAT];

    initial for (int a = 0; a < 2**AW; a++) mem[a] = '0;

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            pipe[0][c*72 +: 72] <= rd_en[c] ? mem[rd_addr[c*AW +: AW]] : 72'd0;
            if (wr_en[c]) mem[wr_addr[c*AW +: AW]] <= wr_data[c*72 +: 72];
        end
        for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
    end
    assign rd_data = pipe[RD_LAT-1];
endmodule

module sim_rmw_counter_quad;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 8;
    localparam int LAT = 3;

    typedef struct packed {
        logic [1:0]  ch;
        logic        join_prev;
        logic        rb;
        logic [7:0]  addr;
        logic [31:0] pkt;
        logic [39:0] byt;
    } vec_t;

    // One request per entry; join_prev puts it in the same cycle as the entry before.
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 8'd5,  32'd1,          40'd64},
        '{2'd1, 1'b0, 1'b0, 8'd5,  32'd1,          40'd100},
        '{2'd2, 1'b0, 1'b0, 8'd5,  32'd2,          40'd1500},
        '{2'd3, 1'b0, 1'b1, 8'd5,  32'd0,          40'd0},
        '{2'd0, 1'b0, 1'b0, 8'd5,  32'd1,          40'd10},
        '{2'd0, 1'b0, 1'b0, 8'd9,  32'hFFFF_FFFF,  40'hFF_FFFF_FFFF},
        '{2'd1, 1'b0, 1'b0, 8'd9,  32'd2,          40'd3},
        '{2'd2, 1'b0, 1'b0, 8'd6,  32'd3,          40'd30},
        '{2'd3, 1'b1, 1'b0, 8'd7,  32'd4,          40'd40},
        '{2'd0, 1'b1, 1'b0, 8'd8,  32'd5,          40'd50},
        '{2'd1, 1'b1, 1'b0, 8'd10, 32'd6,          40'd60},
        '{2'd2, 1'b0, 1'b1, 8'd9,  32'd0,          40'd0},
        '{2'd1, 1'b0, 1'b1, 8'd5,  32'd0,          40'd0},
        '{2'd0, 1'b0, 1'b0, 8'd6,  32'd5,          40'd5},
        '{2'd3, 1'b0, 1'b1, 8'd8,  32'd0,          40'd0}
    };

    logic clk = 0, rst_n = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NCH-1:0]    r_vld, r_rb, rd_en0, wr_en0, rsp_v0;
    logic [NCH*AW-1:0] r_addr, rd_addr0, wr_addr0;
    logic [NCH*32-1:0] r_pkt;
    logic [NCH*40-1:0] r_byt;
    logic [NCH*72-1:0] rd_data0, wr_data0, rsp_d0;
    logic              err0;

    logic [NCH-1:0]    b_vld, rd_en1, wr_en1, rsp_v1;
    logic [NCH*AW-1:0] b_addr, rd_addr1, wr_addr1;
    logic [NCH*32-1:0] b_pkt;
    logic [NCH*40-1:0] b_byt;
    logic [NCH*72-1:0] rd_data1, wr_data1, rsp_d1;
    logic              err1;

    rmw_counter_quad #(.NCH(NCH), .AW(AW), .RD_LAT(LAT), .BANKED(0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(r_vld), .req_rdback(r_rb), .req_addr(r_addr),
        .req_pkt_inc(r_pkt), .req_byte_inc(r_byt), .rd_en(rd_en0), .rd_addr(rd_addr0),
        .rd_data(rd_data0), .wr_en(wr_en0), .wr_addr(wr_addr0), .wr_data(wr_data0),
        .rsp_valid(rsp_v0), .rsp_data(rsp_d0), .map_err(err0));
    sim_mem #(.NCH(NCH), .AW(AW), .RD_LAT(LAT)) m0 (
        .clk(clk), .rd_en(rd_en0), .rd_addr(rd_addr0), .rd_data(rd_data0),
        .wr_en(wr_en0), .wr_addr(wr_addr0), .wr_data(wr_data0));

    rmw_counter_quad #(.NCH(NCH), .AW(AW), .RD_LAT(LAT), .BANKED(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(b_vld), .req_rdback('0), .req_addr(b_addr),
        .req_pkt_inc(b_pkt), .req_byte_inc(b_byt), .rd_en(rd_en1), .rd_addr(rd_addr1),
        .rd_data(rd_data1), .wr_en(wr_en1), .wr_addr(wr_addr1), .wr_data(wr_data1),
        .rsp_valid(rsp_v1), .rsp_data(rsp_d1), .map_err(err1));
    sim_mem #(.NCH(NCH), .AW(AW), .RD_LAT(LAT)) m1 (
        .clk(clk), .rd_en(rd_en1), .rd_addr(rd_addr1), .rd_data(rd_data1),
        .wr_en(wr_en1), .wr_addr(wr_addr1), .wr_data(wr_data1));

    int checks = 0, errors = 0;
    bit done = 0;
    logic [71:0] exp_mem [2**AW];
    logic [71:0] exp_q [NCH][32];
    int q_wr [NCH];
    int q_rd [NCH];

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        r_vld = '0; r_rb = '0; r_addr = '0; r_pkt = '0; r_byt = '0;
    endtask

    // Drives one request slot and advances the reference model (R4, R5).
    task automatic put(input int c, input bit rb, input int a,
                       input logic [31:0] p, input logic [39:0] b);
        r_vld[c] = 1'b1; r_rb[c] = rb;
        r_addr[c*AW +: AW] = a[AW-1:0];
        r_pkt[c*32 +: 32] = p; r_byt[c*40 +: 40] = b;
        if (rb) begin
            exp_q[c][q_wr[c] % 32] = exp_mem[a];
            q_wr[c]++;
            exp_mem[a] = '0;
        end else begin
            exp_mem[a] = {exp_mem[a][71:40] + p, exp_mem[a][39:0] + b};
        end
    endtask

    // Readback responses compared against the model in arrival order (R5, R6).
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst_n && rsp_v0[c]) begin
                if (q_rd[c] == q_wr[c]) begin
                    chk("R5 unexpected response", 72'd1, 72'd0);
                end else begin
                    chk("R5/R6 readback value", rsp_d0[c*72 +: 72], exp_q[c][q_rd[c] % 32]);
                    q_rd[c]++;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cnt, seen;
        for (int a = 0; a < 2**AW; a++) exp_mem[a] = '0;
        for (int c = 0; c < NCH; c++) begin q_wr[c] = 0; q_rd[c] = 0; end
        clr();
        b_vld = '0; b_addr = '0; b_pkt = '0; b_byt = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk("R1 wr_en after reset", {68'd0, wr_en0}, 72'd0);
        chk("R1 rsp_valid after reset", {68'd0, rsp_v0}, 72'd0);
        chk("R1 map_err after reset", {71'd0, err1}, 72'd0);
        rst_n = 1;

        // Table walk: R4 wrap, R6 forwarding, R10 four in one cycle, R5 readbacks
        for (int i = 0; i < NV; i++) begin
            if (!VEC[i].join_prev) begin
                @(negedge clk);
                clr();
            end
            put(int'(VEC[i].ch), VEC[i].rb, int'(VEC[i].addr), VEC[i].pkt, VEC[i].byt);
        end
        @(negedge clk); clr();

        // R2: read issued in the request cycle; R3/R5 latency of a readback
        put(2, 1'b1, 20, 32'd0, 40'd0);
        #1;
        chk("R2 read strobe", {71'd0, rd_en0[2]}, 72'd1);
        chk("R2 read address", {64'd0, rd_addr0[2*AW +: AW]}, 72'd20);
        @(negedge clk); clr();
        cnt = 1;
        while (!rsp_v0[2] && cnt < 20) begin @(negedge clk); cnt++; end
        chk("R3 cycles to write", 72'(cnt), 72'(LAT + 1));
        chk("R3 write address", {64'd0, wr_addr0[2*AW +: AW]}, 72'd20);

        // R7: free mapping accepts odd and even on any channel
        @(negedge clk);
        put(0, 1'b0, 12, 32'd11, 40'd12);
        put(3, 1'b0, 13, 32'd13, 40'd14);
        @(negedge clk); clr();
        repeat (LAT + 3) @(negedge clk);
        chk("R7 no mapping error", {71'd0, err0}, 72'd0);
        for (int c = 0; c < NCH; c++) chk("R5 all responses seen", 72'(q_rd[c]), 72'(q_wr[c]));
        for (int a = 0; a < 24; a++) chk("R4/R6/R10 memory contents", m0.mem[a], exp_mem[a]);

        // R8/R9: banked mode drops a wrong-parity request and latches the error
        b_vld[0] = 1'b1; b_addr[0 +: AW] = 8'd2; b_pkt[0 +: 32] = 32'd1; b_byt[0 +: 40] = 40'd1;
        #1;
        chk("R8 no read for violation", {71'd0, rd_en1[0]}, 72'd0);
        @(negedge clk);
        b_vld = '0;
        chk("R9 error set next cycle", {71'd0, err1}, 72'd1);
        seen = 0;
        for (int k = 0; k < LAT + 3; k++) begin @(negedge clk); if (wr_en1 != 0) seen++; end
        chk("R8 no write for violation", 72'(seen), 72'd0);
        b_vld[0] = 1'b1; b_addr[0 +: AW] = 8'd3; b_pkt[0 +: 32] = 32'd7; b_byt[0 +: 40] = 40'd9;
        @(negedge clk); b_vld = '0;
        repeat (LAT) @(negedge clk);
        chk("R8 legal write strobe", {71'd0, wr_en1[0]}, 72'd1);
        chk("R4 legal write data", wr_data1[0 +: 72], {32'd7, 40'd9});
        repeat (3) @(negedge clk);
        chk("R9 error stays set", {71'd0, err1}, 72'd1);
        chk("R8 memory untouched", m1.mem[2], 72'd0);

        // R1/R9: reset clears the sticky flag
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 reset clears error", {71'd0, err1}, 72'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule